// File: doc/BRIEF.md
# Programmable Status LED Selector

This block drives a small set of status LEDs (two by default). Each LED has its own 4-bit function code. The code chooses which condition the LED shows: link, traffic in either or both directions, collision, line speed, duplex, or a combined mode. In the combined mode the LED is lit while the link is up and flashes while traffic is present.

Activity inputs may be only one clock wide. A retriggerable down-counter stretches them so that a single event stays visible for a programmable number of cycles. A free-running prescaler supplies the flash phase.

The function codes sit in a register bank inside the block, one register per LED. A one-cycle write strobe per LED loads a shared data word. At reset, LED0 shows link and LED1 shows activity. Each LED output comes from a register fed by the selected condition.

Top module: `led_status_sel`

## Requirements
- R1: While reset is asserted every LED output is 0. After reset, LED0 holds function code 0 (link) and LED1 holds code 1 (activity) until they are written.
- R2: Code 0 lights the LED exactly when `link_up` is 1.
- R3: Code 1 lights the LED on stretched transmit or receive activity. Code 2 lights it on transmit activity only. Code 3 lights it on receive activity only.
- R4: Code 4 follows `collision`. Code 5 lights when `speed_100` is 1 (100 Mb/s). Code 6 lights when `speed_100` is 0 (10 Mb/s). Code 7 follows `full_duplex`.
- R5: Under code 8 the LED behaves as follows:
  - It is off while `link_up` is 0.
  - It is steadily on while the link is up and no stretched activity is present.
  - While the link is up and activity is present, it alternates between on and off in runs of exactly BLINK_HALF cycles.
- R6: Codes 9 to 15 hold the LED off whatever the status inputs are.
- R7: A single-cycle activity pulse keeps the selected activity indication lit for exactly STRETCH_CYCLES clock cycles. A new pulse during that window restarts the count.
- R8: An LED output reflects the status inputs sampled at the same rising edge that updates it. A function code written at one edge governs the output from the following edge onward.
- R9: A write strobe changes only the function code of the LEDs whose enable bit is set. All other LEDs keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_wr_en | input | NUM_LEDS | Per-LED write strobe for the function code |
| func_wr_data | input | 4 | Function code to load |
| link_up | input | 1 | Link is established |
| tx_act | input | 1 | Transmit activity event |
| rx_act | input | 1 | Receive activity event |
| collision | input | 1 | Collision present |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | Full-duplex operation |
| led_o | output | NUM_LEDS | LED drive, 1 = lit |

## Verification
Level conditions and the leading edge of a stretched pulse reach `led_o` at the same rising edge that samples them. The bench drives inputs after a falling edge and checks them at the next falling edge. A code write changes the output one edge later than its write edge, and the bench checks both the old and the new value across that pair of edges. Stretch length is checked by counting the observed cycles in which the LED is lit after a pulse. Blinking is checked by measuring run lengths of the LED between transitions, excluding the partial first and last runs. Each table vector is followed by enough idle cycles for every stretch to expire.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;

   localparam int FUNC_W = 4;

   typedef enum logic [FUNC_W-1:0] {
      FN_LINK      = 4'd0,
      FN_ANY_ACT   = 4'd1,
      FN_TX_ACT    = 4'd2,
      FN_RX_ACT    = 4'd3,
      FN_COLLIDE   = 4'd4,
      FN_FAST      = 4'd5,
      FN_SLOW      = 4'd6,
      FN_DUPLEX    = 4'd7,
      FN_LINK_BLNK = 4'd8
   } led_fn_e;

   typedef struct packed {
      logic link;
      logic tx;
      logic rx;
      logic col;
      logic fast;
      logic duplex;
      logic blink;
   } led_status_t;

endpackage

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
   parameter int CYCLES = 2_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   output logic held_o
);
   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (pulse_i) begin
         remain_q <= RELOAD;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign held_o = pulse_i | (remain_q != '0);

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
   parameter int HALF_PERIOD = 5_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase_o
);
   localparam int BW = $clog2(HALF_PERIOD + 1);
   localparam logic [BW-1:0] LAST = BW'(HALF_PERIOD - 1);

   logic [BW-1:0] div_q;
   logic          phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         phase_q <= 1'b1;
      end else if (div_q == LAST) begin
         div_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         div_q   <= div_q + 1'b1;
      end
   end

   assign phase_o = phase_q;

endmodule

// File: rtl/led_func_mux.sv
module led_func_mux
   import led_sel_pkg::*;
(
   input  logic [FUNC_W-1:0] func_i,
   input  led_status_t       stat_i,
   output logic              lit_o
);
   always_comb begin
      case (led_fn_e'(func_i))
         FN_LINK:      lit_o = stat_i.link;
         FN_ANY_ACT:   lit_o = stat_i.tx | stat_i.rx;
         FN_TX_ACT:    lit_o = stat_i.tx;
         FN_RX_ACT:    lit_o = stat_i.rx;
         FN_COLLIDE:   lit_o = stat_i.col;
         FN_FAST:      lit_o = stat_i.fast;
         FN_SLOW:      lit_o = ~stat_i.fast;
         FN_DUPLEX:    lit_o = stat_i.duplex;
         FN_LINK_BLNK: lit_o = stat_i.link & (~(stat_i.tx | stat_i.rx) | stat_i.blink);
         default:      lit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/led_status_sel.sv
module led_status_sel
   import led_sel_pkg::*;
#(
   parameter int NUM_LEDS       = 2,
   parameter int STRETCH_CYCLES = 2_500_000,
   parameter int BLINK_HALF     = 5_000_000,
   parameter logic [NUM_LEDS*FUNC_W-1:0] DEFAULT_FUNCS = 8'h10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_LEDS-1:0] func_wr_en,
   input  logic [3:0]          func_wr_data,
   input  logic                link_up,
   input  logic                tx_act,
   input  logic                rx_act,
   input  logic                collision,
   input  logic                speed_100,
   input  logic                full_duplex,
   output logic [NUM_LEDS-1:0] led_o
);
   localparam int ACT_CH = 2;

   generate
      if (NUM_LEDS < 1 || NUM_LEDS > 16) begin : g_bad_leds
         $error("NUM_LEDS must be within 1..16");
      end
      if (STRETCH_CYCLES < 1) begin : g_bad_stretch
         $error("STRETCH_CYCLES must be at least 1");
      end
      if (BLINK_HALF < 1) begin : g_bad_blink
         $error("BLINK_HALF must be at least 1");
      end
   endgenerate

   logic [ACT_CH-1:0] act_raw;
   logic [ACT_CH-1:0] act_held;
   logic              blink_phase;
   led_status_t       stat;

   logic [NUM_LEDS-1:0][FUNC_W-1:0] func_q;
   logic [NUM_LEDS-1:0]             lit;

   assign act_raw = {rx_act, tx_act};

   generate
      for (genvar c = 0; c < ACT_CH; c++) begin : g_stretch
         led_pulse_stretch #(.CYCLES(STRETCH_CYCLES)) u_stretch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pulse_i(act_raw[c]),
            .held_o (act_held[c])
         );
      end
   endgenerate

   led_blink_gen #(.HALF_PERIOD(BLINK_HALF)) u_blink (
      .clk    (clk),
      .rst_n  (rst_n),
      .phase_o(blink_phase)
   );

   always_comb begin
      stat.link   = link_up;
      stat.tx     = act_held[0];
      stat.rx     = act_held[1];
      stat.col    = collision;
      stat.fast   = speed_100;
      stat.duplex = full_duplex;
      stat.blink  = blink_phase;
   end

   generate
      for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               func_q[i] <= DEFAULT_FUNCS[i*FUNC_W +: FUNC_W];
            end else if (func_wr_en[i]) begin
               func_q[i] <= func_wr_data;
            end
         end

         led_func_mux u_mux (
            .func_i(func_q[i]),
            .stat_i(stat),
            .lit_o (lit[i])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               led_o[i] <= 1'b0;
            end else begin
               led_o[i] <= lit[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/led_status_sel_chk.sv
module led_status_sel_chk #(
   parameter int NUM_LEDS = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      link_up,
   input logic                      tx_act,
   input logic                      speed_100,
   input logic [NUM_LEDS-1:0]       led_o,
   input logic [NUM_LEDS-1:0][3:0]  func_q
);
   always_comb begin
      if (!rst_n) begin
         AST_RESET_DARK: assert (led_o == '0); // R1
      end
   end

   generate
      for (genvar i = 0; i < NUM_LEDS; i++) begin : g_chk
         AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(func_q[i]) == 4'd0) |-> (led_o[i] == $past(link_up))); // R2
         AST_TX_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(func_q[i]) == 4'd2 && $past(tx_act)) |-> led_o[i]); // R3
         AST_FAST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(func_q[i]) == 4'd5) |-> (led_o[i] == $past(speed_100))); // R4
         AST_BLINK_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(func_q[i]) == 4'd8 && !$past(link_up)) |-> !led_o[i]); // R5
         AST_OFF_CODES: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(func_q[i]) >= 4'd9) |-> !led_o[i]); // R6
      end
   endgenerate

endmodule

bind led_status_sel led_status_sel_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .link_up  (link_up),
   .tx_act   (tx_act),
   .speed_100(speed_100),
   .led_o    (led_o),
   .func_q   (func_q)
);

// File: tb/led_status_sel_tb.sv
module led_status_sel_tb;
   localparam int STR   = 6;
   localparam int BLINK = 4;
   localparam int NV    = 13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] func_wr_en = '0;
   logic [3:0] func_wr_data = '0;
   logic       link_up = 0, tx_act = 0, rx_act = 0;
   logic       collision = 0, speed_100 = 0, full_duplex = 0;
   logic [1:0] led_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   led_status_sel #(.NUM_LEDS(2), .STRETCH_CYCLES(STR), .BLINK_HALF(BLINK)) u_dut (
      .clk(clk), .rst_n(rst_n), .func_wr_en(func_wr_en), .func_wr_data(func_wr_data),
      .link_up(link_up), .tx_act(tx_act), .rx_act(rx_act), .collision(collision),
      .speed_100(speed_100), .full_duplex(full_duplex), .led_o(led_o)
   );

   always #10 clk = ~clk;

   // {code0, code1, link, tx, rx, col, fast, duplex, exp0, exp1}
   localparam logic [15:0] VEC [NV] = '{
      {4'd0, 4'd1, 6'b100000, 2'b10},  // R2 link, R3 idle
      {4'd0, 4'd1, 6'b010000, 2'b01},  // R3 tx on any-activity
      {4'd0, 4'd1, 6'b001000, 2'b01},  // R3 rx on any-activity
      {4'd2, 4'd3, 6'b010000, 2'b10},  // R3 tx-only vs rx-only
      {4'd2, 4'd3, 6'b001000, 2'b01},  // R3
      {4'd4, 4'd5, 6'b000110, 2'b11},  // R4 collision, fast
      {4'd4, 4'd5, 6'b000000, 2'b00},  // R4
      {4'd6, 4'd7, 6'b000001, 2'b11},  // R4 slow, duplex
      {4'd6, 4'd7, 6'b000010, 2'b00},  // R4
      {4'd9, 4'd15, 6'b111111, 2'b00}, // R6
      {4'd12, 4'd10, 6'b111101, 2'b00},// R6
      {4'd8, 4'd8, 6'b100000, 2'b11},  // R5 link, no activity
      {4'd8, 4'd8, 6'b011000, 2'b00}   // R5 no link
   };

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_func(input logic [1:0] mask, input logic [3:0] code);
      func_wr_en = mask;
      func_wr_data = code;
      tick();
      func_wr_en = '0;
   endtask

   task automatic clear_inputs;
      {link_up, tx_act, rx_act, collision, speed_100, full_duplex} = '0;
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
   end

   initial begin
      logic rec [48];
      int   runs [$];
      int   cnt;
      int   seen_hi, seen_lo;

      // R1: reset holds LEDs dark even with link asserted
      link_up = 1;
      repeat (3) tick();
      check("R1 reset dark", led_o, 2'b00);
      rst_n = 1;
      tick();
      check("R1 default codes link", led_o, 2'b01);
      tx_act = 1;
      tick();
      tx_act = 0;
      check("R1 default code1 activity", led_o, 2'b11);
      clear_inputs();
      repeat (STR + 2) tick();

      // table walk
      for (int i = 0; i < NV; i++) begin
         write_func(2'b01, VEC[i][15:12]);
         write_func(2'b10, VEC[i][11:8]);
         {link_up, tx_act, rx_act, collision, speed_100, full_duplex} = VEC[i][7:2];
         tick();
         check($sformatf("R2-table vec %0d", i), led_o, {VEC[i][0], VEC[i][1]});
         clear_inputs();
         repeat (STR + 2) tick();
      end

      // R7: stretch length and retrigger on LED1 with code 1
      write_func(2'b10, 4'd1);
      tx_act = 1; tick(); tx_act = 0;
      cnt = 0;
      while (led_o[1] && cnt < 50) begin cnt++; tick(); end
      check("R7 stretch length", cnt, STR);
      repeat (3) tick();
      rx_act = 1; tick(); rx_act = 0;
      tick(); tick();
      rx_act = 1; tick(); rx_act = 0;
      cnt = 0;
      while (led_o[1] && cnt < 50) begin cnt++; tick(); end
      check("R7 retrigger restarts", cnt, STR);
      repeat (3) tick();

      // R5: blink under code 8 with continuous activity
      write_func(2'b01, 4'd8);
      link_up = 1;
      tx_act = 1;
      tick();
      for (int c = 0; c < 48; c++) begin rec[c] = led_o[0]; tick(); end
      cnt = 1; seen_hi = 0; seen_lo = 0;
      for (int c = 1; c < 48; c++) begin
         if (rec[c]) seen_hi++; else seen_lo++;
         if (rec[c] != rec[c-1]) begin runs.push_back(cnt); cnt = 1; end
         else cnt++;
      end
      check("R5 blink both levels seen", (seen_hi > 0) && (seen_lo > 0), 1);
      check("R5 blink run count", runs.size() >= 8, 1);
      for (int k = 1; k < runs.size(); k++)
         check($sformatf("R5 blink run %0d", k), runs[k], BLINK);
      tx_act = 0;
      repeat (STR + 2) tick();
      cnt = 0;
      for (int c = 0; c < 2 * BLINK + 1; c++) begin
         if (led_o[0]) cnt++;
         tick();
      end
      check("R5 steady on without activity", cnt, 2 * BLINK + 1);
      link_up = 0;
      tick();
      check("R5 off when link drops", led_o[0], 1'b0);

      // R8 / R9: write timing and per-LED independence
      clear_inputs();
      write_func(2'b01, 4'd4);
      write_func(2'b10, 4'd1);
      repeat (STR + 2) tick();
      collision = 1;
      speed_100 = 1;
      tick();
      check("R9 led0 collision, led1 unchanged", led_o, 2'b01);
      write_func(2'b10, 4'd5);
      check("R8 old code governs write edge", led_o[1], 1'b0);
      tick();
      check("R8 new code next edge", led_o, 2'b11);
      write_func(2'b01, 4'd9);
      tick();
      check("R9 led1 keeps code on led0 write", led_o, 2'b10);

      finish_up();
   end

endmodule